// File: doc/BRIEF.md
# Branch Trace Message Generator

This block follows the stream of instructions that a processor retires and emits a program-trace message only when control flow leaves the straight-line path. A message is produced for a taken branch or an exception. Two other things also produce one: a run of sequential instructions long enough to fill the 8-bit instruction counter, or the loss of a message while the output is stalled. Each message carries a type code, the number of instructions retired since the previous message (this one included), an address field and the bit length of that field.

A normal message reports the destination address relative to the previously reported one. The relative value is the XOR of the two addresses, and the length field gives the position of its highest set bit. A direct branch reports no address, because a tool that holds the program image can recompute the target. Several events upgrade the next message to a sync message with the full destination address: leaving reset, a rising trace enable, an exception, a tool-driven sync request, or an earlier dropped message.

The message appears in a single output register with a valid/ready handshake. Downstream logic serializes it onto pins or stores it in a buffer.

Top module: `btm_trace_gen`

## Requirements
- R1: A retired instruction that is neither taken nor an exception produces no message, except as stated in R8.
- R2: A taken direct branch with no sync pending produces code 0x03, icount = instructions retired since the last message including the branch, address 0 and length 0.
- R3: A taken indirect branch with no sync pending produces code 0x04. Its address is the XOR of its destination and the last reported destination, and its length is the index of the highest set bit of that XOR plus one (0 when the two are equal).
- R4: A sync message uses code 0x0B for a direct branch and 0x0C for an indirect branch or exception, carries the full destination address, and has length equal to the address width.
- R5: After reset, and after trace enable rises, the first branch or exception message is a sync message.
- R6: A retired instruction flagged as an exception always produces code 0x0C with the full destination address.
- R7: A sync request pulse makes the next branch or exception message a sync message, including one that retires in the same cycle as the pulse.
- R8: When 255 sequential instructions have retired since the last message, the 255th produces code 0x1B with icount 255, address 0 and length 0, and counting restarts. A branch retiring at that point produces its branch message instead.
- R9: While msg_valid is high and msg_ready is low, all message outputs hold their values.
- R10: A message that falls due while the output is stalled is dropped. The next message that is emitted has msg_lost set, and if it is a branch or exception message it is a sync message.
- R11: While trace enable is low, retired instructions produce no messages and the instruction count restarts from zero.
- R12: Every message appears on the outputs one clock edge after the instruction that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_en | input | 1 | Trace enable |
| sync_req | input | 1 | Tool-driven request to force the next message to sync |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_pc | input | AW | Address at which execution continues after the retired instruction |
| ret_taken | input | 1 | Retired instruction is a taken branch |
| ret_indirect | input | 1 | Taken branch target comes from a register |
| ret_exc | input | 1 | Retired instruction entered an exception |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_valid | output | 1 | Message register holds a message |
| msg_code | output | 6 | Message type code |
| msg_icnt | output | 8 | Instructions since the previous message |
| msg_addr | output | AW | Relative or full address field |
| msg_alen | output | LW | Significant bits in msg_addr |
| msg_lost | output | 1 | An earlier message was dropped |

## Verification
The most delicate overlaps are a branch that retires at the exact moment the counter would saturate, and a new message that falls due in the same cycle the consumer stalls. The first is provoked by retiring 254 sequential instructions and then a branch, and again by 254 followed by one more sequential instruction. The result is judged by the code and the icount. The second is provoked by dropping msg_ready while branches keep retiring, and by random ready patterns during a mixed stream. The behavioural model checks each cycle that the stalled message holds and that the next emitted message is flagged as lost and upgraded to sync.

// File: rtl/btm_pkg.sv
package btm_pkg;
  typedef enum logic [5:0] {
    BTM_DIR      = 6'h03,
    BTM_IND      = 6'h04,
    BTM_DIR_SYNC = 6'h0B,
    BTM_IND_SYNC = 6'h0C,
    BTM_RES_FULL = 6'h1B
  } btm_code_e;
endpackage

// File: rtl/btm_addr_comp.sv
module btm_addr_comp #(
  parameter int AW = 32,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] dest,
  input  logic [AW-1:0] last,
  input  logic          full,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] alen
);
  logic [AW-1:0] delta;
  logic [LW-1:0] top_bit;

  assign delta = dest ^ last;

  always_comb begin
    top_bit = '0;
    for (int i = 0; i < AW; i++) begin
      if (delta[i]) top_bit = LW'(i + 1);
    end
  end

  assign addr = full ? dest : delta;
  assign alen = full ? LW'(AW) : top_bit;

  always_comb begin
    a_len_range_r3: assert (alen <= LW'(AW));
  end
endmodule

// File: rtl/btm_icount.sv
module btm_icount #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] cnt_next,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIMIT = {CW{1'b1}};
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_next = cnt_q + 1'b1;
  assign at_limit = (cnt_next == LIMIT);

  p_cnt_below_max_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q != LIMIT);
  p_clear_wins_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0);
endmodule

// File: rtl/btm_out_reg.sv
module btm_out_reg #(
  parameter int AW = 32,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [5:0]    in_code,
  input  logic [7:0]    in_icnt,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_alen,
  input  logic          in_lost,
  input  logic          ready,
  output logic          stall,
  output logic          valid,
  output logic [5:0]    code,
  output logic [7:0]    icnt,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] alen,
  output logic          lost
);
  assign stall = valid & ~ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      code  <= '0;
      icnt  <= '0;
      addr  <= '0;
      alen  <= '0;
      lost  <= 1'b0;
    end else if (load && !stall) begin
      valid <= 1'b1;
      code  <= in_code;
      icnt  <= in_icnt;
      addr  <= in_addr;
      alen  <= in_alen;
      lost  <= in_lost;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  p_hold_when_stalled_r9: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(code) && $stable(icnt) &&
                           $stable(addr) && $stable(alen) && $stable(lost)));
endmodule

// File: rtl/btm_trace_gen.sv
module btm_trace_gen #(
  parameter int AW = 32,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trc_en,
  input  logic          sync_req,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic          ret_taken,
  input  logic          ret_indirect,
  input  logic          ret_exc,
  input  logic          msg_ready,
  output logic          msg_valid,
  output logic [5:0]    msg_code,
  output logic [7:0]    msg_icnt,
  output logic [AW-1:0] msg_addr,
  output logic [LW-1:0] msg_alen,
  output logic          msg_lost
);
  import btm_pkg::*;

  logic          en_d, pend_q, lost_q;
  logic [AW-1:0] last_q;
  logic          rv, disc, due, is_res, sync_now, en_rise, stall;
  logic [7:0]    cnt_next;
  logic          at_limit;
  logic [AW-1:0] cmp_addr, new_addr;
  logic [LW-1:0] cmp_alen, new_alen;
  btm_code_e     new_code;

  assign rv       = ret_valid & trc_en;
  assign disc     = ret_taken | ret_exc;
  assign en_rise  = trc_en & ~en_d;
  assign sync_now = pend_q | sync_req | en_rise | ret_exc;
  assign is_res   = rv & ~disc & at_limit;
  assign due      = rv & (disc | at_limit);

  btm_icount #(.CW(8)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (~trc_en | due),
    .step     (rv & ~disc),
    .cnt_next (cnt_next),
    .at_limit (at_limit)
  );

  btm_addr_comp #(.AW(AW), .LW(LW)) u_addr (
    .dest (ret_pc),
    .last (last_q),
    .full (sync_now),
    .addr (cmp_addr),
    .alen (cmp_alen)
  );

  always_comb begin
    new_addr = cmp_addr;
    new_alen = cmp_alen;
    if (is_res) begin
      new_code = BTM_RES_FULL;
      new_addr = '0;
      new_alen = '0;
    end else if (ret_exc || ret_indirect) begin
      new_code = sync_now ? BTM_IND_SYNC : BTM_IND;
    end else begin
      new_code = sync_now ? BTM_DIR_SYNC : BTM_DIR;
      if (!sync_now) begin
        new_addr = '0;
        new_alen = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      pend_q <= 1'b1;
      lost_q <= 1'b0;
      last_q <= '0;
    end else begin
      en_d <= trc_en;
      if (due && stall)                  pend_q <= 1'b1;
      else if (due && !is_res && sync_now) pend_q <= 1'b0;
      else                               pend_q <= pend_q | sync_req | en_rise;
      if (due) lost_q <= stall;
      if (rv && disc) last_q <= ret_pc;
    end
  end

  btm_out_reg #(.AW(AW), .LW(LW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (due),
    .in_code (new_code),
    .in_icnt (cnt_next),
    .in_addr (new_addr),
    .in_alen (new_alen),
    .in_lost (lost_q),
    .ready   (msg_ready),
    .stall   (stall),
    .valid   (msg_valid),
    .code    (msg_code),
    .icnt    (msg_icnt),
    .addr    (msg_addr),
    .alen    (msg_alen),
    .lost    (msg_lost)
  );

  p_direct_no_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_code == BTM_DIR) |-> (msg_alen == '0 && msg_addr == '0));
  p_sync_full_len_r4: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && (msg_code == BTM_DIR_SYNC || msg_code == BTM_IND_SYNC))
      |-> msg_alen == LW'(AW));
  p_lost_is_sync_r10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_lost && msg_code != BTM_RES_FULL)
      |-> (msg_code == BTM_DIR_SYNC || msg_code == BTM_IND_SYNC));
  p_exc_is_sync_r6: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && trc_en && ret_exc && !(msg_valid && !msg_ready))
      |=> (msg_valid && msg_code == BTM_IND_SYNC && msg_addr == $past(ret_pc)));
  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (rst)
    (!trc_en && !msg_valid) |=> !msg_valid);
endmodule

// File: tb/tb_btm_trace_gen.sv
module tb_btm_trace_gen;
  localparam int AW = 32;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trc_en = 1'b0, sync_req = 1'b0, ret_valid = 1'b0;
  logic [AW-1:0] ret_pc = '0;
  logic ret_taken = 1'b0, ret_indirect = 1'b0, ret_exc = 1'b0, msg_ready = 1'b1;
  logic msg_valid, msg_lost;
  logic [5:0] msg_code;
  logic [7:0] msg_icnt;
  logic [AW-1:0] msg_addr;
  logic [LW-1:0] msg_alen;

  always #2.5 clk = ~clk;

  btm_trace_gen #(.AW(AW), .LW(LW)) dut (
    .clk(clk), .rst(rst), .trc_en(trc_en), .sync_req(sync_req),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_taken(ret_taken),
    .ret_indirect(ret_indirect), .ret_exc(ret_exc), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_code(msg_code), .msg_icnt(msg_icnt),
    .msg_addr(msg_addr), .msg_alen(msg_alen), .msg_lost(msg_lost)
  );

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference state
  bit m_valid = 0, m_lost = 0, pend = 1, lost_p = 0, en_d = 0;
  int m_code = 0, m_icnt = 0, m_len = 0, cnt = 0;
  logic [AW-1:0] m_addr = '0, last = '0;

  function automatic int bitlen(logic [AW-1:0] x);
    int n = 0;
    for (int i = 0; i < AW; i++) if (x[i]) n = i + 1;
    return n;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_valid = 0; m_lost = 0; pend = 1; lost_p = 0; en_d = 0; cnt = 0; last = '0;
    end else begin
      bit stall, newm, sync, rise;
      int c, n, l; logic [AW-1:0] a;
      stall = m_valid && !msg_ready;
      rise = trc_en && !en_d;
      sync = pend || sync_req || rise || ret_exc;
      newm = 0; c = 0; n = 0; a = '0; l = 0;
      if (!trc_en) cnt = 0;
      else if (ret_valid) begin
        if (ret_taken || ret_exc) begin
          newm = 1; n = cnt + 1; cnt = 0;
          if (sync) begin
            c = (ret_exc || ret_indirect) ? 'h0C : 'h0B; a = ret_pc; l = AW;
          end else if (ret_indirect) begin
            c = 'h04; a = ret_pc ^ last; l = bitlen(a);
          end else c = 'h03;
          last = ret_pc;
        end else if (cnt + 1 == 255) begin
          newm = 1; c = 'h1B; n = 255; cnt = 0; sync = 0;
        end else cnt++;
      end
      if (newm && stall) begin pend = 1; lost_p = 1; end
      else begin
        if (newm && sync) pend = 0;
        else pend = pend || sync_req || rise;
        if (newm) begin
          m_valid = 1; m_code = c; m_icnt = n; m_addr = a; m_len = l;
          m_lost = lost_p; lost_p = 0;
        end else if (m_valid && msg_ready) m_valid = 0;
      end
      en_d = trc_en;
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(msg_valid == m_valid, "valid", msg_valid, m_valid);
      if (m_valid && msg_valid) begin
        chk(msg_code == m_code[5:0], "code", msg_code, m_code);
        chk(msg_icnt == m_icnt[7:0], "icnt", msg_icnt, m_icnt);
        chk(msg_addr == m_addr, "addr", msg_addr, m_addr);
        chk(msg_alen == m_len[LW-1:0], "alen", msg_alen, m_len);
        chk(msg_lost == m_lost, "lost", msg_lost, m_lost);
      end
    end
  end

  task automatic step(bit v, bit tk, bit ind, bit ex, logic [AW-1:0] pc);
    @(negedge clk); #0.5;
    ret_valid = v; ret_taken = tk; ret_indirect = ind; ret_exc = ex; ret_pc = pc;
  endtask

  task automatic seq(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, '0);
  endtask

  task automatic expect_msg(int code, int icnt, string req);
    @(negedge clk); #0.5;
    ret_valid = 0; ret_taken = 0; ret_exc = 0;
    cur_req = req;
    chk(msg_valid && msg_code == code[5:0], "directed code", msg_code, code);
    chk(msg_icnt == icnt[7:0], "directed icnt", msg_icnt, icnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R5";
    chk(msg_valid == 0, "reset valid", msg_valid, 0);
    rst = 0; trc_en = 1;
    cur_req = "R1"; seq(10);
    step(0, 0, 0, 0, '0);
    chk(msg_valid == 0, "no msg for sequential", msg_valid, 0);
    cur_req = "R5"; step(1, 1, 0, 0, 32'h1000); expect_msg('h0B, 11, "R5");
    cur_req = "R2"; seq(3); step(1, 1, 0, 0, 32'h1040); expect_msg('h03, 4, "R2");
    cur_req = "R3"; step(1, 1, 1, 0, 32'h1440); expect_msg('h04, 1, "R3");
    chk(msg_alen == 11, "R3 len", msg_alen, 11);
    step(1, 1, 1, 0, 32'h1440); expect_msg('h04, 1, "R3");
    chk(msg_alen == 0, "R3 equal len", msg_alen, 0);
    cur_req = "R6"; step(1, 0, 0, 1, 32'h0000_0100); expect_msg('h0C, 1, "R6");
    chk(msg_addr == 32'h100, "R6 full addr", msg_addr, 32'h100);
    cur_req = "R7"; @(negedge clk); #0.5; sync_req = 1; @(negedge clk); #0.5; sync_req = 0;
    step(1, 1, 0, 0, 32'h2000); expect_msg('h0B, 1, "R7");
    @(negedge clk); #0.5; sync_req = 1; ret_valid = 1; ret_taken = 1; ret_indirect = 1; ret_pc = 32'h3000;
    @(negedge clk); #0.5; sync_req = 0; ret_valid = 0; ret_taken = 0; ret_indirect = 0;
    cur_req = "R7"; chk(msg_code == 6'h0C, "same-cycle sync", msg_code, 'h0C);
    cur_req = "R8"; seq(255); expect_msg('h1B, 255, "R8");
    cur_req = "R8"; seq(254); step(1, 1, 0, 0, 32'h3100); expect_msg('h03, 255, "R8");
    cur_req = "R9"; msg_ready = 0;
    step(1, 1, 0, 0, 32'h3200); step(0, 0, 0, 0, '0);
    cur_req = "R10"; step(1, 1, 1, 0, 32'h3300); step(0, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    #0.5; msg_ready = 1;
    step(1, 1, 1, 0, 32'h3310); expect_msg('h0C, 1, "R10");
    chk(msg_lost == 1, "R10 lost flag", msg_lost, 1);
    cur_req = "R11"; trc_en = 0;
    for (int i = 0; i < 20; i++) step(1, i % 2, i % 3 == 0, 0, 32'h4000 + i);
    step(0, 0, 0, 0, '0); @(negedge clk);
    chk(msg_valid == 0, "R11 disabled silent", msg_valid, 0);
    #0.5; trc_en = 1; step(1, 1, 0, 0, 32'h5000); expect_msg('h0B, 1, "R11");
    cur_req = "R12";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #0.5;
      msg_ready = ($urandom % 4) != 0;
      sync_req = ($urandom % 50) == 0;
      if (($urandom % 300) == 0) trc_en = ~trc_en;
      ret_valid = ($urandom % 4) != 0;
      ret_taken = ($urandom % 6) == 0;
      ret_indirect = $urandom % 2;
      ret_exc = ($urandom % 40) == 0;
      ret_pc = {$urandom} & 32'h0000_FFFF;
    end
    @(negedge clk); #0.5; ret_valid = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule